// File: doc/BRIEF.md
# DRAM bank activation timing checker

This block sits beside a DDR2-style command bus and samples it on every rising clock edge. It recognises activate, precharge, read and write commands. For each of the banks it records whether the bank is open, which row is open, and how many clocks have passed since that bank's last activate and last precharge. A shared counter measures the spacing between activates to any bank. From this state the block reports, for every bank and every cycle, whether an activate, a read/write or a precharge issued in that cycle would be legal.

When a command that is actually issued breaks a rule, a sticky violation flag is set and a 3-bit code names the broken rule. All timing values are static inputs given in clocks. The row-activate-to-column delay may be covered partly by a posted additive latency, so a read or write can legally be issued earlier than the raw delay allows. Illegal commands are still applied to the tracked state, so the checker keeps following what the memory itself would see. Refresh, mode programming, data bursts, the precharge-all form and the four-activate window are not modelled.

Top module: `dbc_act_checker`

## Requirements
- R1: Commands are decoded at the rising edge with cmd_cs_n low: {ras_n,cas_n,we_n} = 011 is activate, 010 is precharge, 101 is read and 100 is write. Every other pattern, and any pattern with cmd_cs_n high, has no effect. An activate opens bank cmd_bank and stores cmd_row as its open row, and q_row shows the stored row of bank q_bank.
- R2: While rst is high at a rising edge, all banks close and all counters go to their saturated value. After that, bank_open = 0, act_ok and pre_ok are all ones, rw_ok = 0, viol_flag = 0 and viol_code = 0.
- R3: A read or write to a closed bank is illegal, code 5.
- R4: An activate to an open bank is illegal, code 1.
- R5: An activate that comes less than cfg_tras + cfg_trp clocks after the previous activate to the same bank is illegal, code 2.
- R6: An activate that comes less than cfg_trp clocks after the last precharge of that bank is illegal, code 3.
- R7: An activate that comes less than cfg_trrd clocks after an activate to any bank is illegal, code 4.
- R8: A read or write issued k clocks after the activate of its bank is legal only if k + AL >= cfg_trcd, code 6. AL is cfg_al, and values above 4 count as 4.
- R9: A precharge to an open bank less than cfg_tras clocks after its activate is illegal, code 7. A precharge to a closed bank is legal and has no effect.
- R10: When one activate breaks several rules, the reported code follows the priority open (1), then precharge spacing (3), then same-bank spacing (2), then cross-bank spacing (4).
- R11: viol_flag stays set until reset. With STICKY_FIRST = 1 (default), viol_code keeps the first violation. With STICKY_FIRST = 0, it shows the latest one.
- R12: Clock counters saturate, so after any idle time of at least the largest timing value, every rule counts as met.
- R13: An illegal command is still applied: an early precharge closes the bank, and an illegal activate opens the bank, replaces its row and restarts its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, commands sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_cs_n | input | 1 | Chip select, active low |
| cmd_ras_n | input | 1 | Row strobe, active low |
| cmd_cas_n | input | 1 | Column strobe, active low |
| cmd_we_n | input | 1 | Write enable, active low |
| cmd_bank | input | BA_W (3) | Bank address of the command |
| cmd_row | input | ROW_W (14) | Row address carried by an activate |
| cfg_trcd | input | CNT_W (6) | Activate to read/write delay, clocks |
| cfg_tras | input | CNT_W (6) | Minimum activate to precharge time, clocks |
| cfg_trp | input | CNT_W (6) | Precharge to activate time, clocks |
| cfg_trrd | input | CNT_W (6) | Activate to activate spacing across banks, clocks |
| cfg_al | input | 3 | Posted additive latency, 0 to 4 |
| q_bank | input | BA_W (3) | Bank whose open row is shown on q_row |
| bank_open | output | NBANK (8) | One bit per bank, set while the bank is open |
| act_ok | output | NBANK (8) | Activate to this bank would be legal in this cycle |
| rw_ok | output | NBANK (8) | Read/write to this bank would be legal in this cycle |
| pre_ok | output | NBANK (8) | Precharge to this bank would be legal in this cycle |
| q_row | output | ROW_W (14) | Stored row of bank q_bank |
| viol_flag | output | 1 | Sticky violation flag |
| viol_code | output | 3 | Code of the recorded violation, 0 when none |

## Verification
One activate can break more than one rule in the same cycle. The bench provokes this by issuing a second activate to the same bank on the very next clock, which breaks the open-bank, same-bank spacing and cross-bank spacing rules at once. The reported code must be the open-bank code. Recording a new violation can also fall in the same cycle as an existing sticky one. A closed-bank read after that activate must leave the first code on the default instance but move the code on a second instance built with STICKY_FIRST = 0, while the flag stays set on both.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_ACT  = 2'd1,
      CMD_PRE  = 2'd2,
      CMD_RW   = 2'd3
   } cmd_e;

   typedef enum logic [2:0] {
      V_NONE     = 3'd0,
      V_ACT_OPEN = 3'd1,
      V_TRC      = 3'd2,
      V_TRP      = 3'd3,
      V_TRRD     = 3'd4,
      V_CLOSED   = 3'd5,
      V_TRCD     = 3'd6,
      V_TRAS     = 3'd7
   } viol_e;

endpackage

// File: rtl/dbc_decode.sv
module dbc_decode
   import dbc_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);

   always_comb begin
      cmd = CMD_NONE;
      if (!cs_n) begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  cmd = CMD_ACT;
            3'b010:  cmd = CMD_PRE;
            3'b101:  cmd = CMD_RW;
            3'b100:  cmd = CMD_RW;
            default: cmd = CMD_NONE;
         endcase
      end
   end

endmodule

// File: rtl/dbc_bank.sv
module dbc_bank #(
   parameter int ROW_W = 14,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             act_hit,
   input  logic             pre_hit,
   input  logic [ROW_W-1:0] row_in,
   input  logic [CNT_W-1:0] cfg_tras,
   input  logic [CNT_W-1:0] cfg_trp,
   input  logic [CNT_W:0]   cfg_trc,
   input  logic [CNT_W:0]   cfg_trcd_w,
   input  logic [CNT_W:0]   al_w,
   output logic             is_open,
   output logic [ROW_W-1:0] open_row,
   output logic             f_trp,
   output logic             f_trc,
   output logic             f_trcd,
   output logic             f_tras
);

   localparam logic [CNT_W-1:0] MAXC = '1;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] since_act;
   logic [CNT_W-1:0] since_pre;
   logic             close_now;

   // a precharge only acts on an open bank; an activate in the same cycle is impossible
   assign close_now = pre_hit && is_open;

   always_ff @(posedge clk) begin
      if (rst) begin
         is_open   <= 1'b0;
         open_row  <= '0;
         since_act <= MAXC;
         since_pre <= MAXC;
      end else begin
         if (act_hit) begin
            is_open   <= 1'b1;
            open_row  <= row_in;
            since_act <= ONE;
         end else if (since_act != MAXC) begin
            since_act <= since_act + ONE;
         end

         if (close_now) begin
            is_open   <= 1'b0;
            since_pre <= ONE;
         end else if (since_pre != MAXC) begin
            since_pre <= since_pre + ONE;
         end
      end
   end

   assign f_trp  = since_pre < cfg_trp;
   assign f_trc  = {1'b0, since_act} < cfg_trc;
   assign f_trcd = ({1'b0, since_act} + al_w) < cfg_trcd_w;
   assign f_tras = since_act < cfg_tras;

   p_open_after_act_r1: assert property (@(posedge clk) disable iff (rst)
      act_hit |=> is_open);

   p_row_capture_r1: assert property (@(posedge clk) disable iff (rst)
      act_hit |=> open_row == $past(row_in));

   p_close_after_pre_r13: assert property (@(posedge clk) disable iff (rst)
      (pre_hit && !act_hit) |=> !is_open);

   p_sat_hold_r12: assert property (@(posedge clk) disable iff (rst)
      (since_act == MAXC && !act_hit) |=> since_act == MAXC);

   p_pre_sat_hold_r12: assert property (@(posedge clk) disable iff (rst)
      (since_pre == MAXC && !close_now) |=> since_pre == MAXC);

endmodule

// File: rtl/dbc_rrd.sv
module dbc_rrd #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             act_any,
   input  logic [CNT_W-1:0] cfg_trrd,
   output logic             rrd_ok
);

   localparam logic [CNT_W-1:0] MAXC = '1;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] since_any;

   always_ff @(posedge clk) begin
      if (rst) begin
         since_any <= MAXC;
      end else if (act_any) begin
         since_any <= ONE;
      end else if (since_any != MAXC) begin
         since_any <= since_any + ONE;
      end
   end

   assign rrd_ok = since_any >= cfg_trrd;

   p_rrd_block_r7: assert property (@(posedge clk) disable iff (rst)
      (act_any && cfg_trrd > ONE && $stable(cfg_trrd)) |=> !rrd_ok);

endmodule

// File: rtl/dbc_viol.sv
module dbc_viol
   import dbc_pkg::*;
#(
   parameter bit STICKY_FIRST = 1'b1
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  hit,
   input  viol_e code_in,
   output logic  flag,
   output viol_e code
);

   logic take;

   generate
      if (STICKY_FIRST) begin : g_first
         assign take = hit && !flag;

         p_first_kept_r11: assert property (@(posedge clk) disable iff (rst)
            flag |=> $stable(code));
      end else begin : g_last
         assign take = hit;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         flag <= 1'b0;
         code <= V_NONE;
      end else begin
         if (hit) flag <= 1'b1;
         if (take) code <= code_in;
      end
   end

   p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
      flag |=> flag);

   p_capture_r11: assert property (@(posedge clk) disable iff (rst)
      hit |=> (flag && code != V_NONE));

endmodule

// File: rtl/dbc_act_checker.sv
module dbc_act_checker
   import dbc_pkg::*;
#(
   parameter int NBANK        = 8,
   parameter int ROW_W        = 14,
   parameter int CNT_W        = 6,
   parameter int AL_MAX       = 4,
   parameter bit STICKY_FIRST = 1'b1,
   parameter int BA_W         = $clog2(NBANK)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cmd_cs_n,
   input  logic             cmd_ras_n,
   input  logic             cmd_cas_n,
   input  logic             cmd_we_n,
   input  logic [BA_W-1:0]  cmd_bank,
   input  logic [ROW_W-1:0] cmd_row,
   input  logic [CNT_W-1:0] cfg_trcd,
   input  logic [CNT_W-1:0] cfg_tras,
   input  logic [CNT_W-1:0] cfg_trp,
   input  logic [CNT_W-1:0] cfg_trrd,
   input  logic [2:0]       cfg_al,
   input  logic [BA_W-1:0]  q_bank,
   output logic [NBANK-1:0] bank_open,
   output logic [NBANK-1:0] act_ok,
   output logic [NBANK-1:0] rw_ok,
   output logic [NBANK-1:0] pre_ok,
   output logic [ROW_W-1:0] q_row,
   output logic             viol_flag,
   output logic [2:0]       viol_code
);

   localparam logic [2:0] AL_CAP = 3'(AL_MAX);

   generate
      if (NBANK != (1 << BA_W)) begin : g_bad_nbank
         $error("dbc_act_checker: NBANK must be a power of two");
      end
      if (CNT_W < 3) begin : g_bad_cnt
         $error("dbc_act_checker: CNT_W must be at least 3");
      end
      if (AL_MAX < 0 || AL_MAX > 7) begin : g_bad_al
         $error("dbc_act_checker: AL_MAX must lie in 0..7");
      end
   endgenerate

   cmd_e             cmd;
   logic [2:0]       al_eff;
   logic [CNT_W:0]   al_w;
   logic [CNT_W:0]   trc_w;
   logic [CNT_W:0]   trcd_w;
   logic             rrd_ok;
   logic [NBANK-1:0] f_trp, f_trc, f_trcd, f_tras;
   logic [ROW_W-1:0] rows [NBANK];
   viol_e            vcode;
   viol_e            code_q;

   dbc_decode i_decode (
      .cs_n  (cmd_cs_n),
      .ras_n (cmd_ras_n),
      .cas_n (cmd_cas_n),
      .we_n  (cmd_we_n),
      .cmd   (cmd)
   );

   assign al_eff = (cfg_al > AL_CAP) ? AL_CAP : cfg_al;
   assign al_w   = {{(CNT_W-2){1'b0}}, al_eff};
   assign trc_w  = {1'b0, cfg_tras} + {1'b0, cfg_trp};
   assign trcd_w = {1'b0, cfg_trcd};

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         logic act_b, pre_b;
         assign act_b = (cmd == CMD_ACT) && (cmd_bank == BA_W'(b));
         assign pre_b = (cmd == CMD_PRE) && (cmd_bank == BA_W'(b));

         dbc_bank #(
            .ROW_W (ROW_W),
            .CNT_W (CNT_W)
         ) i_bank (
            .clk        (clk),
            .rst        (rst),
            .act_hit    (act_b),
            .pre_hit    (pre_b),
            .row_in     (cmd_row),
            .cfg_tras   (cfg_tras),
            .cfg_trp    (cfg_trp),
            .cfg_trc    (trc_w),
            .cfg_trcd_w (trcd_w),
            .al_w       (al_w),
            .is_open    (bank_open[b]),
            .open_row   (rows[b]),
            .f_trp      (f_trp[b]),
            .f_trc      (f_trc[b]),
            .f_trcd     (f_trcd[b]),
            .f_tras     (f_tras[b])
         );

         assign act_ok[b] = !bank_open[b] && !f_trp[b] && !f_trc[b] && rrd_ok;
         assign rw_ok[b]  = bank_open[b] && !f_trcd[b];
         assign pre_ok[b] = !bank_open[b] || !f_tras[b];
      end
   endgenerate

   dbc_rrd #(
      .CNT_W (CNT_W)
   ) i_rrd (
      .clk      (clk),
      .rst      (rst),
      .act_any  (cmd == CMD_ACT),
      .cfg_trrd (cfg_trrd),
      .rrd_ok   (rrd_ok)
   );

   // rule selection for the command on the bus, ordered by priority
   always_comb begin
      vcode = V_NONE;
      unique case (cmd)
         CMD_ACT: begin
            if (bank_open[cmd_bank])  vcode = V_ACT_OPEN;
            else if (f_trp[cmd_bank]) vcode = V_TRP;
            else if (f_trc[cmd_bank]) vcode = V_TRC;
            else if (!rrd_ok)         vcode = V_TRRD;
         end
         CMD_RW: begin
            if (!bank_open[cmd_bank])  vcode = V_CLOSED;
            else if (f_trcd[cmd_bank]) vcode = V_TRCD;
         end
         CMD_PRE: begin
            if (bank_open[cmd_bank] && f_tras[cmd_bank]) vcode = V_TRAS;
         end
         default: vcode = V_NONE;
      endcase
   end

   dbc_viol #(
      .STICKY_FIRST (STICKY_FIRST)
   ) i_viol (
      .clk     (clk),
      .rst     (rst),
      .hit     (vcode != V_NONE),
      .code_in (vcode),
      .flag    (viol_flag),
      .code    (code_q)
   );

   assign viol_code = code_q;
   assign q_row     = rows[q_bank];

   p_closed_access_r3: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_RW && !bank_open[cmd_bank]) |=> viol_flag);

   p_open_act_r4: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_ACT && bank_open[cmd_bank]) |=> (viol_flag && bank_open[$past(cmd_bank)]));

   p_rw_ok_needs_open_r8: assert property (@(posedge clk) disable iff (rst)
      (rw_ok & ~bank_open) == '0);

   always_comb begin
      if (!rst) begin
         a_al_cap_r8: assert (al_eff <= AL_CAP);
      end
   end

endmodule

// File: tb/test_dbc_act_checker.sv
module test_dbc_act_checker;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [2:0]  bank = '0;
   logic [13:0] row = '0;
   logic [5:0]  trcd = 6'd4, tras = 6'd6, trp = 6'd3, trrd = 6'd2;
   logic [2:0]  al = 3'd0;
   logic [2:0]  qb = '0;

   logic [7:0]  bank_open, act_ok, rw_ok, pre_ok;
   logic [13:0] q_row;
   logic        viol_flag;
   logic [2:0]  viol_code;

   logic [7:0]  l_open, l_act, l_rw, l_pre;
   logic [13:0] l_row;
   logic        l_flag;
   logic [2:0]  l_code;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dbc_act_checker i_dbc_act_checker (
      .clk(clk), .rst(rst),
      .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
      .cmd_bank(bank), .cmd_row(row),
      .cfg_trcd(trcd), .cfg_tras(tras), .cfg_trp(trp), .cfg_trrd(trrd), .cfg_al(al),
      .q_bank(qb),
      .bank_open(bank_open), .act_ok(act_ok), .rw_ok(rw_ok), .pre_ok(pre_ok),
      .q_row(q_row), .viol_flag(viol_flag), .viol_code(viol_code)
   );

   dbc_act_checker #(.STICKY_FIRST(1'b0)) i_last (
      .clk(clk), .rst(rst),
      .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
      .cmd_bank(bank), .cmd_row(row),
      .cfg_trcd(trcd), .cfg_tras(tras), .cfg_trp(trp), .cfg_trrd(trrd), .cfg_al(al),
      .q_bank(qb),
      .bank_open(l_open), .act_ok(l_act), .rw_ok(l_rw), .pre_ok(l_pre),
      .q_row(l_row), .viol_flag(l_flag), .viol_code(l_code)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // kind: 0 nop, 1 act, 2 pre, 3 read, 4 write, 5 act pattern deselected, 6 cs low all high
   task automatic drive(input int kind, input logic [2:0] b, input logic [13:0] r);
      bank = b;
      row  = r;
      case (kind)
         1: {cs_n, ras_n, cas_n, we_n} = 4'b0011;
         2: {cs_n, ras_n, cas_n, we_n} = 4'b0010;
         3: {cs_n, ras_n, cas_n, we_n} = 4'b0101;
         4: {cs_n, ras_n, cas_n, we_n} = 4'b0100;
         5: {cs_n, ras_n, cas_n, we_n} = 4'b1011;
         6: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
         default: {cs_n, ras_n, cas_n, we_n} = 4'b1111;
      endcase
   endtask

   task automatic issue(input int kind, input logic [2:0] b, input logic [13:0] r);
      drive(kind, b, r);
      @(negedge clk);
      drive(0, 3'd0, 14'd0);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      drive(0, 3'd0, 14'd0);
      idle(2);
      rst = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R2", "bank_open", bank_open, 8'h00);
      chk("R2", "act_ok", act_ok, 8'hFF);
      chk("R2", "rw_ok", rw_ok, 8'h00);
      chk("R2", "pre_ok", pre_ok, 8'hFF);
      chk("R2", "flag", viol_flag, 0);
      chk("R2", "code", viol_code, 0);
   endtask

   task automatic t_decode();
      do_reset();
      qb = 3'd3;
      issue(1, 3'd3, 14'h1ABC);
      chk("R1", "open after act", bank_open, 8'h08);
      chk("R1", "row", q_row, 14'h1ABC);
      issue(5, 3'd5, 14'h0005);
      chk("R1", "deselected act ignored", bank_open, 8'h08);
      issue(6, 3'd5, 14'h0005);
      chk("R1", "cs-only pattern ignored", bank_open, 8'h08);
      idle(1);
      chk("R8", "rw_ok at tRCD", rw_ok[3], 1);
      issue(3, 3'd3, 14'h0);
      issue(4, 3'd3, 14'h0);
      chk("R1", "legal read/write flag", viol_flag, 0);
   endtask

   task automatic t_closed();
      do_reset();
      chk("R3", "rw_ok closed", rw_ok[2], 0);
      issue(4, 3'd2, 14'h0);
      chk("R3", "flag", viol_flag, 1);
      chk("R3", "code", viol_code, 5);
   endtask

   task automatic t_rcd();
      do_reset();
      issue(1, 3'd1, 14'h0);
      idle(2);
      chk("R8", "rw_ok early al0", rw_ok[1], 0);
      issue(3, 3'd1, 14'h0);
      chk("R8", "code al0", viol_code, 6);
      al = 3'd1;
      do_reset();
      issue(1, 3'd1, 14'h0);
      idle(2);
      chk("R8", "rw_ok al1", rw_ok[1], 1);
      issue(3, 3'd1, 14'h0);
      chk("R8", "flag al1", viol_flag, 0);
      al = 3'd7;
      trcd = 6'd6;
      do_reset();
      issue(1, 3'd1, 14'h0);
      chk("R8", "al clamp rw_ok", rw_ok[1], 0);
      issue(4, 3'd1, 14'h0);
      chk("R8", "al clamp code", viol_code, 6);
      al = 3'd0;
      trcd = 6'd4;
   endtask

   task automatic t_ras();
      do_reset();
      issue(1, 3'd0, 14'h0);
      idle(4);
      chk("R9", "pre_ok early", pre_ok[0], 0);
      issue(2, 3'd0, 14'h0);
      chk("R9", "code", viol_code, 7);
      chk("R13", "early pre closes", bank_open[0], 0);
      do_reset();
      issue(2, 3'd4, 14'h0);
      chk("R9", "pre closed flag", viol_flag, 0);
      chk("R9", "pre closed no open", bank_open, 8'h00);
   endtask

   task automatic t_open();
      do_reset();
      issue(1, 3'd2, 14'h0);
      idle(20);
      chk("R4", "act_ok open", act_ok[2], 0);
      issue(1, 3'd2, 14'h0);
      chk("R4", "code", viol_code, 1);
   endtask

   task automatic t_rc();
      do_reset();
      qb = 3'd0;
      issue(1, 3'd0, 14'h0011);
      idle(1);
      issue(2, 3'd0, 14'h0);
      idle(3);
      chk("R5", "act_ok tRC", act_ok[0], 0);
      issue(1, 3'd0, 14'h0022);
      chk("R5", "latest code", l_code, 2);
      chk("R11", "first code kept", viol_code, 7);
      chk("R13", "illegal act opens", bank_open[0], 1);
      chk("R13", "illegal act row", q_row, 14'h0022);
   endtask

   task automatic t_rp();
      do_reset();
      issue(1, 3'd0, 14'h0);
      idle(10);
      issue(2, 3'd0, 14'h0);
      chk("R6", "act_ok after pre", act_ok[0], 0);
      issue(1, 3'd0, 14'h0);
      chk("R6", "code", viol_code, 3);
   endtask

   task automatic t_rrd();
      do_reset();
      issue(1, 3'd0, 14'h0);
      chk("R7", "act_ok other bank", act_ok[1], 0);
      issue(1, 3'd1, 14'h0);
      chk("R7", "code", viol_code, 4);
      do_reset();
      issue(1, 3'd0, 14'h0);
      idle(1);
      chk("R7", "act_ok at tRRD", act_ok[1], 1);
      issue(1, 3'd1, 14'h0);
      chk("R7", "legal flag", viol_flag, 0);
   endtask

   task automatic t_prio();
      do_reset();
      issue(1, 3'd0, 14'h0);
      issue(1, 3'd0, 14'h0);
      chk("R10", "open wins", viol_code, 1);
      issue(3, 3'd5, 14'h0);
      chk("R11", "flag held", viol_flag, 1);
      chk("R11", "first code", viol_code, 1);
      chk("R11", "latest code", l_code, 5);
      chk("R11", "latest flag", l_flag, 1);
   endtask

   task automatic t_sat();
      do_reset();
      issue(1, 3'd6, 14'h0);
      idle(200);
      chk("R12", "pre_ok after idle", pre_ok[6], 1);
      issue(2, 3'd6, 14'h0);
      idle(3);
      chk("R12", "act_ok after idle", act_ok[6], 1);
      issue(1, 3'd6, 14'h0);
      chk("R12", "no false violation", viol_flag, 0);
   endtask

   initial begin
      idle(1);
      t_reset();
      t_decode();
      t_closed();
      t_rcd();
      t_ras();
      t_open();
      t_rc();
      t_rp();
      t_rrd();
      t_prio();
      t_sat();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog all-requirements actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule